// File: doc/BRIEF.md
# Destination Address Filter with Four Programmable Entries

This block decides whether a received Ethernet frame is addressed to this station. The receive path hands it the six-byte destination address of each frame together with a one-cycle strobe. One clock later the block returns a 32-bit match code and an accept flag. The match code is a single bit in a fixed position that tells the receive path which rule hit. The accept flag tells it whether to keep the frame.

Software programs up to four station addresses through a small register write port. Each entry is split into a 32-bit lower word and a 16-bit upper word. An entry takes part in matching only after its upper word has been written, so a half-updated address can never produce a false hit. Two configuration inputs give extra control. One suppresses broadcast recognition. The other makes the block accept every frame, matched or not.

Top module: `daf_filter`

## Requirements
- R1: After reset every entry is invalid, and `res_valid`, `res_code` and `res_accept` are all zero. An all-zero address strobed straight after reset produces code 0.
- R2: An entry's lower word holds address bytes 0..3, with byte 0 (the first received, `dest_addr[47:40]`) in bits 31:24. Its upper word takes bytes 4 and 5 from `wr_data[15:0]`, byte 4 in bits 15:8. Bits 31:16 of an upper-word write are ignored.
- R3: Writing an entry's lower word makes that entry invalid.
- R4: Writing an entry's upper word makes that entry valid. The register offsets are lower/upper 0x98/0x9C for entry 1, 0xA0/0xA4 for entry 2, 0xA8/0xAC for entry 3 and 0xB0/0xB4 for entry 4.
- R5: Valid entries are checked in the order 1, 2, 3, 4, and only the first hit is reported. The hit is reported as bit 26, 25, 24 or 23 respectively, so at most one bit of the code is set.
- R6: If no entry hits, the all-ones address reports bit 31 while `cfg_no_bcast` is 0.
- R7: While `cfg_no_bcast` is 1, the all-ones address reports bit 31 never. It can still hit a programmed entry.
- R8: `res_accept` is 1 exactly when the code is nonzero or `cfg_copy_all` was 1 at the strobe.
- R9: A strobe in cycle N gives `res_valid` = 1 in cycle N+1 and 0 otherwise. The code and accept flag hold until the next strobe. A register write on the same edge as a strobe does not affect that strobe's result.
- R10: Writes to offsets other than the eight entry offsets change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| cfg_no_bcast | input | 1 | Disable broadcast recognition |
| cfg_copy_all | input | 1 | Accept every frame |
| dest_valid | input | 1 | Destination address strobe |
| dest_addr | input | 48 | Destination address, first byte in bits 47:40 |
| res_valid | output | 1 | Result strobe, one cycle after `dest_valid` |
| res_accept | output | 1 | Frame accept decision |
| res_code | output | 32 | One-hot match code |

## Verification
The bench checks an entry whose lower word has been rewritten but whose upper word has not; a design with sticky valid bits would still match it. It programs the same address into several entries and the broadcast address into entry 4. A wrong priority or ordering would then report several bits, the wrong bit, or bit 31 instead of 23. It issues a write on the same edge as a strobe, which a design comparing against post-write state would get wrong. It also sends upper-word data with junk in the top bits and writes to neighbouring offsets, which a loose decoder would let corrupt an entry.

// File: rtl/daf_pkg.sv
// Package: shared constants for the destination address filter.
// Assumes a 48-bit address split into a 32-bit lower and 16-bit upper word.
package daf_pkg;
    localparam int unsigned ADDR_BITS = 48;
    localparam int unsigned LO_BITS   = 32;
    localparam int unsigned HI_BITS   = ADDR_BITS - LO_BITS;
    localparam int unsigned CODE_BITS = 32;
    localparam int unsigned BCAST_POS = 31;
endpackage

// File: rtl/daf_entry.sv
// One programmable address entry: stores the lower/upper words, tracks
// validity (set by an upper write, cleared by a lower write) and compares.
// Assumes wr_addr is a byte offset; LO_OFS and HI_OFS are fixed per entry.
module daf_entry
    import daf_pkg::*;
#(
    parameter int unsigned OFS_W  = 8,
    parameter logic [7:0]  LO_OFS = 8'h98,
    parameter logic [7:0]  HI_OFS = 8'h9C
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     wr_addr,
    input  logic [LO_BITS-1:0]   wr_data,
    input  logic [ADDR_BITS-1:0] addr,
    output logic                 hit
);
    logic [LO_BITS-1:0] lo_q;
    logic [HI_BITS-1:0] hi_q;
    logic               vld_q;
    logic               wr_lo, wr_hi;

    // Decode the two offsets that belong to this entry.
    always_comb begin
        wr_lo = wr_en && (wr_addr == OFS_W'(LO_OFS));
        wr_hi = wr_en && (wr_addr == OFS_W'(HI_OFS));
    end

    // Store the address words and track validity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            vld_q <= 1'b0;
        end else begin
            if (wr_lo) begin
                lo_q  <= wr_data;
                vld_q <= 1'b0;
            end
            if (wr_hi) begin
                hi_q  <= wr_data[HI_BITS-1:0];
                vld_q <= 1'b1;
            end
        end
    end

    // Compare the incoming address against the stored entry.
    always_comb hit = vld_q && (addr[ADDR_BITS-1:HI_BITS] == lo_q)
                            && (addr[HI_BITS-1:0] == hi_q);

    a_r3_low_invalidates: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> !vld_q);
    a_r4_high_validates: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> vld_q);
endmodule

// File: rtl/daf_prio.sv
// Priority encoder: the lowest-numbered hitting entry wins and sets its own
// bit (FIRST_POS downwards); otherwise broadcast may set BCAST_POS.
// Assumes FIRST_POS >= N-1 and BCAST_POS above all entry bits.
module daf_prio
    import daf_pkg::*;
#(
    parameter int unsigned N         = 4,
    parameter int unsigned FIRST_POS = 26
) (
    input  logic [N-1:0]         hits,
    input  logic                 is_bcast,
    input  logic                 no_bcast,
    output logic [CODE_BITS-1:0] code
);
    // Walk from the last entry to the first so the first hit overrides.
    always_comb begin
        code = '0;
        if (is_bcast && !no_bcast) code[BCAST_POS] = 1'b1;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                code = '0;
                code[FIRST_POS - i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/daf_filter.sv
// Top: four address entries, broadcast detection, priority encoding and a
// result register loaded one clock after each address strobe.
// Assumes the address and configuration are stable for the strobe cycle.
module daf_filter
    import daf_pkg::*;
#(
    parameter int unsigned N_ENTRIES = 4,
    parameter int unsigned OFS_W     = 8,
    parameter logic [7:0]  BASE_OFS  = 8'h98,
    parameter int unsigned STRIDE    = 8,
    parameter int unsigned FIRST_POS = 26
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OFS_W-1:0]     wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 cfg_no_bcast,
    input  logic                 cfg_copy_all,
    input  logic                 dest_valid,
    input  logic [47:0]          dest_addr,
    output logic                 res_valid,
    output logic                 res_accept,
    output logic [31:0]          res_code
);
    localparam int unsigned HI_STEP = STRIDE / 2;

    logic [N_ENTRIES-1:0] hits;
    logic                 is_bcast;
    logic [CODE_BITS-1:0] code_d;

    // One entry per programmable address.
    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        daf_entry #(
            .OFS_W  (OFS_W),
            .LO_OFS (8'(BASE_OFS + g * STRIDE)),
            .HI_OFS (8'(BASE_OFS + g * STRIDE + HI_STEP))
        ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .addr    (dest_addr),
            .hit     (hits[g])
        );
    end

    // Detect the all-ones broadcast address.
    always_comb is_bcast = &dest_addr;

    daf_prio #(.N(N_ENTRIES), .FIRST_POS(FIRST_POS)) u_prio (
        .hits     (hits),
        .is_bcast (is_bcast),
        .no_bcast (cfg_no_bcast),
        .code     (code_d)
    );

    // Capture the result one clock after the strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
            res_code   <= '0;
        end else begin
            res_valid <= dest_valid;
            if (dest_valid) begin
                res_code   <= code_d;
                res_accept <= (code_d != '0) || cfg_copy_all;
            end
        end
    end

    a_r9_result_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        dest_valid |=> res_valid);
    a_r9_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !dest_valid |=> (!res_valid && $stable(res_code)));
    a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(res_code));
    a_r7_bcast_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_valid && cfg_no_bcast) |=> !res_code[BCAST_POS]);
    a_r8_copy_all_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (dest_valid && cfg_copy_all) |=> res_accept);
endmodule

// File: tb/tb_daf_filter.sv
module tb_daf_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cfg_no_bcast = 1'b0, cfg_copy_all = 1'b0;
    logic        dest_valid = 1'b0;
    logic [47:0] dest_addr = '0;
    logic        res_valid, res_accept;
    logic [31:0] res_code;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    logic [31:0] m_lo [4];
    logic [15:0] m_hi [4];
    bit          m_vld [4];
    logic [31:0] e_code = '0;
    logic        e_acc = 1'b0;

    always #10 clk = ~clk;

    daf_filter dut (.*);

    // Watchdog: counts clocks and forces a failure plus summary on expiry.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic logic [31:0] ref_code(logic [47:0] a, bit nb);
        for (int i = 0; i < 4; i++)
            if (m_vld[i] && m_lo[i] == a[47:16] && m_hi[i] == a[15:0])
                return 32'd1 << (26 - i);
        if (a == '1 && !nb) return 32'h8000_0000;
        return '0;
    endfunction

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive inputs, advance the reference model, compare outputs.
    task automatic step(string tag, bit we, logic [7:0] wa, logic [31:0] wd,
                        bit dv, logic [47:0] da, bit nb, bit ca);
        logic e_vld;
        wr_en = we; wr_addr = wa; wr_data = wd;
        dest_valid = dv; dest_addr = da; cfg_no_bcast = nb; cfg_copy_all = ca;
        e_vld = dv;
        if (dv) begin
            e_code = ref_code(da, nb);
            e_acc  = (e_code != 0) || ca;
        end
        if (we) begin
            for (int i = 0; i < 4; i++) begin
                if (wa == 8'(8'h98 + 8 * i)) begin m_lo[i] = wd; m_vld[i] = 0; end
                if (wa == 8'(8'h9C + 8 * i)) begin m_hi[i] = wd[15:0]; m_vld[i] = 1; end
            end
        end
        @(posedge clk); @(negedge clk);
        cmp({tag, " valid"},  {31'd0, res_valid}, {31'd0, e_vld});
        cmp({tag, " code"},   res_code, e_code);
        cmp({tag, " accept"}, {31'd0, res_accept}, {31'd0, e_acc});
    endtask

    task automatic wr(string tag, logic [7:0] a, logic [31:0] d);
        step(tag, 1, a, d, 0, '0, 0, 0);
    endtask

    task automatic probe(string tag, logic [47:0] a, bit nb = 0, bit ca = 0);
        step(tag, 0, '0, '0, 1, a, nb, ca);
    endtask

    localparam logic [47:0] A1 = 48'h0211_2233_4455;
    localparam logic [47:0] A2 = 48'h0266_7788_99AA;

    initial begin
        for (int i = 0; i < 4; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_vld[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cmp("R1 reset valid", {31'd0, res_valid}, 32'd0);
        cmp("R1 reset code", res_code, 32'd0);
        cmp("R1 reset accept", {31'd0, res_accept}, 32'd0);
        step("R1 idle", 0, '0, '0, 0, '0, 0, 0);
        probe("R1 zero address no match", 48'h0);
        // R6, R7, R8: broadcast and copy-all
        probe("R6 broadcast", '1);
        probe("R7 no-bcast", '1, 1);
        probe("R8 copy-all no match", A1, 0, 1);
        probe("R8 no match rejected", A1);
        // R4, R2: entry 2 lower only stays invalid, upper validates
        wr("R4 e2 low", 8'hA0, A1[47:16]);
        probe("R4 e2 not yet valid", A1);
        wr("R2 e2 high junk top", 8'hA4, {16'hDEAD, A1[15:0]});
        probe("R2 e2 match bit25", A1);
        step("R9 hold", 0, '0, '0, 0, '0, 0, 0);
        // R5: same address in entry 1 wins
        wr("R5 e1 low", 8'h98, A1[47:16]);
        wr("R5 e1 high", 8'h9C, {16'h0, A1[15:0]});
        probe("R5 e1 over e2", A1);
        wr("R5 e3 low", 8'hA8, A2[47:16]);
        wr("R5 e3 high", 8'hAC, {16'h0, A2[15:0]});
        wr("R5 e4 low", 8'hB0, A2[47:16]);
        wr("R5 e4 high", 8'hB4, {16'h0, A2[15:0]});
        probe("R5 e3 over e4", A2);
        // R3: lower rewrite invalidates entry 1 then entry 3
        wr("R3 e1 low", 8'h98, A1[47:16]);
        probe("R3 e2 wins after e1 invalid", A1);
        wr("R3 e3 low", 8'hA8, A2[47:16]);
        probe("R3 e4 wins after e3 invalid", A2);
        // R6, R7: broadcast programmed into entry 4
        wr("R6 e4 low", 8'hB0, 32'hFFFF_FFFF);
        wr("R6 e4 high", 8'hB4, 32'h0000_FFFF);
        probe("R6 entry over broadcast", '1);
        probe("R7 entry hit with no-bcast", '1, 1);
        // R10: writes to unused offsets
        wr("R10 off 0x90", 8'h90, 32'h0);
        wr("R10 off 0x9A", 8'h9A, 32'h0);
        wr("R10 off 0xB8", 8'hB8, 32'h0);
        probe("R10 e2 intact", A1);
        probe("R10 e4 intact", '1);
        // R9: write and strobe on the same edge uses prior state
        step("R9 same-edge write", 1, 8'hA0, 32'h0, 1, A1, 0, 0);
        probe("R9 after write e2 invalid", A1);
        // R9: back-to-back strobes
        probe("R9 b2b first", '1, 0, 0);
        probe("R9 b2b second", A2, 0, 0);
        probe("R8 accept with copy-all and match", '1, 0, 1);
        step("R9 idle hold", 0, '0, '0, 0, '0, 0, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule